// File: doc/BRIEF.md
# Multiplexed-Bus Burst Target

This block is a 32-bit target for a synchronous bus that carries address and data on the same lines. The first clock of a bus cycle carries the address and a command code. The target decodes both. If the cycle belongs to it, the target claims it by pulling a device-select line low on the next clock. Words then move on each clock where both the initiator-ready line and the target-ready line are low. The target holds two small register spaces: a 16-word memory window at a base address set by a parameter, and a separate 4-word configuration space. The configuration space is reachable only while a per-slot select input is high during the address phase.

Bursts are linear. The word index starts at the address bits above the byte offset and steps by one after every completed data phase, so a word can move on every clock in both directions. A burst may not run past the last word of the space it addresses. On that word the target raises a stop request together with target-ready, which forces a disconnect. The party that drove the address/data lines on a clock drives even parity over those 32 bits and the 4 command/byte-enable lines on the following clock. The target checks the parity it receives and keeps a sticky local error flag.

The control logic is a four-state machine:
- IDLE waits for a cycle start. It goes to XFER when the cycle hits this target, and to SKIP when it does not.
- XFER claims the cycle and completes data phases. It goes back to IDLE when a word moves while frame is high. It goes to DISC when a word moves on the last index of the window while frame is still low.
- DISC holds device-select and stop low, with target-ready high, until frame rises, then goes to IDLE.
- SKIP ignores the cycle until frame rises, then goes to IDLE.

Top module: `busif_target`

## Requirements
- R1: After reset, devsel_n, trdy_n and stop_n are high, ad_oe, par_oe and perr_flag are low, and every word of both spaces reads as zero.
- R2: A cycle is claimed when, in its address phase (frame_n falling from idle), one of two conditions holds. Either cbe_n is 4'b0110 (memory read) or 4'b0111 (memory write), ad_in[31:6] equals the base address bits [31:6] and ad_in[1:0] is 2'b00. Or the conditions of R9 hold. On the clock after the address phase, devsel_n and trdy_n are both low.
- R3: A cycle is never claimed, and devsel_n stays high for the whole cycle, if any of these holds: the command is not supported, the memory address lies outside the window, or a configuration command arrives with idsel low. Such a cycle changes no stored word.
- R4: In a write, a word is stored only on a clock where irdy_n and trdy_n are both low. Byte lane b (ad_in[8b+7:8b]) is written only when cbe_n[b] is low.
- R5: In a read, ad_oe is high during data phases and ad_out carries the stored word at the current index.
- R6: The word index starts at ad_in[5:2] for memory (ad_in[3:2] for configuration) and rises by one after each completed data phase. A clock with irdy_n high moves no word and leaves the index unchanged.
- R7: On the last index of the addressed space (15 for memory, 3 for configuration), stop_n is low together with trdy_n. If frame_n is still low when that word moves, the next clocks show trdy_n high with devsel_n and stop_n low, until the clock after frame_n is seen high, when all three are released.
- R8: A data phase that completes while frame_n is high ends the cycle. On the next clock devsel_n, trdy_n and stop_n are high.
- R9: Configuration read 4'b1010 and configuration write 4'b1011 with idsel high and ad_in[1:0] equal to 2'b00 reach a 4-word space that is separate from the memory window.
- R10: On the clock after each read data phase, par_oe is high and par_out is the even parity of ad_out and cbe_n from the previous clock.
- R11: par_in is compared, one clock later, with the even parity of ad_in and cbe_n for every address phase and every completed write data phase. A mismatch sets perr_flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Cycle in progress; released for the final data phase |
| irdy_n | input | 1 | Initiator ready |
| idsel | input | 1 | Per-slot select for configuration cycles |
| cbe_n | input | 4 | Command in address phase, active-low byte enables in data phases |
| ad_in | input | 32 | Address/data lines as driven by the initiator |
| par_in | input | 1 | Parity from the initiator, one clock late |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Target drives the address/data lines |
| par_out | output | 1 | Parity of target-driven read data, one clock late |
| par_oe | output | 1 | Target drives the parity line |
| devsel_n | output | 1 | Device select, target has claimed the cycle |
| trdy_n | output | 1 | Target ready |
| stop_n | output | 1 | Target asks the initiator to stop |
| perr_flag | output | 1 | Sticky parity error flag |

## Verification
A wrong state shows at the ports within one clock. A missed claim leaves devsel_n high on the clock after the address phase. A state machine stuck in XFER or DISC keeps devsel_n low on the clock after the cycle should have ended. A wrong or late index step shows on the very next read data phase, because ad_out carries a word other than the one the scoreboard expected. It also shows as a burst that stops on the wrong word count. Write-side faults such as a wrong byte lane, a stray store during a wait clock, or a store from an unclaimed cycle do not show right away. They surface when those words are read back, and every write in the sequence is read back after it.

// File: rtl/busif_pkg.sv
package busif_pkg;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DISC,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/busif_parity.sv
module busif_parity #(
    parameter int W = 36
) (
    input  logic [W-1:0] bits,
    output logic         odd
);
    assign odd = ^bits;
endmodule

// File: rtl/busif_regfile.sv
module busif_regfile #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    idx,
    input  logic [LANES-1:0] lane_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] words [DEPTH];

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) begin
                    words[w][8*b +: 8] <= '0;
                end
            end else if (we && lane_en[b]) begin
                words[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = words[idx];
endmodule

// File: rtl/busif_ctrl.sv
module busif_ctrl
    import busif_pkg::*;
#(
    parameter logic [31:0] MEM_BASE  = 32'h0001_0000,
    parameter int          MEM_WORDS = 16,
    parameter int          CFG_WORDS = 4,
    localparam int MEM_AW  = $clog2(MEM_WORDS),
    localparam int CFG_AW  = $clog2(CFG_WORDS),
    localparam int WIN_LSB = MEM_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic [3:0]        cbe_n,
    input  logic [31:0]       ad_in,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              ad_oe,
    output logic              addr_ph,
    output logic              we_mem,
    output logic              we_cfg,
    output logic              sel_cfg,
    output logic [MEM_AW-1:0] ptr
);
    tgt_state_e state, nxt;
    logic       is_rd;
    logic       hit_mem, hit_cfg, hit, at_last, xfer;

    always_comb begin
        hit_mem = ((cbe_n == CMD_MEM_RD) || (cbe_n == CMD_MEM_WR))
                  && (ad_in[31:WIN_LSB] == MEM_BASE[31:WIN_LSB])
                  && (ad_in[1:0] == 2'b00);
        hit_cfg = idsel && ((cbe_n == CMD_CFG_RD) || (cbe_n == CMD_CFG_WR))
                  && (ad_in[1:0] == 2'b00);
        hit     = hit_mem || hit_cfg;
        at_last = sel_cfg ? (ptr == MEM_AW'(CFG_WORDS - 1))
                          : (ptr == MEM_AW'(MEM_WORDS - 1));
        xfer    = (state == ST_XFER) && !irdy_n;
        addr_ph = (state == ST_IDLE) && !frame_n;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!frame_n) nxt = hit ? ST_XFER : ST_SKIP;
            ST_XFER: if (!irdy_n) begin
                         if (frame_n)      nxt = ST_IDLE;
                         else if (at_last) nxt = ST_DISC;
                     end
            ST_DISC: if (frame_n) nxt = ST_IDLE;
            ST_SKIP: if (frame_n) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ptr     <= '0;
            is_rd   <= 1'b0;
            sel_cfg <= 1'b0;
        end else begin
            state <= nxt;
            if (addr_ph && hit) begin
                sel_cfg <= hit_cfg;
                is_rd   <= !cbe_n[0];
                ptr     <= hit_cfg ? MEM_AW'(ad_in[CFG_AW+1:2]) : ad_in[MEM_AW+1:2];
            end else if (xfer && !at_last) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    always_comb begin
        devsel_n = !((state == ST_XFER) || (state == ST_DISC));
        trdy_n   = !(state == ST_XFER);
        stop_n   = !((state == ST_DISC) || ((state == ST_XFER) && at_last));
        ad_oe    = (state == ST_XFER) && is_rd;
        we_mem   = xfer && !is_rd && !sel_cfg;
        we_cfg   = xfer && !is_rd && sel_cfg;
    end

    assert_trdy_needs_devsel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);
    assert_claim_next_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ph && hit) |=> (!devsel_n && !trdy_n));
    assert_no_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ph && !hit) |=> devsel_n);
    assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && !frame_n && stop_n) |=> (ptr == $past(ptr) + 1'b1));
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> (ptr == $past(ptr)));
    assert_disconnect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !stop_n && !irdy_n && !frame_n) |=> (trdy_n && !stop_n && !devsel_n));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n));
endmodule

// File: rtl/busif_target.sv
module busif_target #(
    parameter logic [31:0] MEM_BASE  = 32'h0001_0000,
    parameter int          MEM_WORDS = 16,
    parameter int          CFG_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] ad_in,
    input  logic        par_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        par_out,
    output logic        par_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        perr_flag
);
    localparam int MEM_AW = $clog2(MEM_WORDS);
    localparam int CFG_AW = $clog2(CFG_WORDS);

    logic              addr_ph, we_mem, we_cfg, sel_cfg;
    logic [MEM_AW-1:0] ptr;
    logic [31:0]       mem_rd, cfg_rd;
    logic              rx_par, tx_par, chk_pend, chk_exp;

    busif_ctrl #(
        .MEM_BASE(MEM_BASE), .MEM_WORDS(MEM_WORDS), .CFG_WORDS(CFG_WORDS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .cbe_n(cbe_n), .ad_in(ad_in),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ad_oe(ad_oe),
        .addr_ph(addr_ph), .we_mem(we_mem), .we_cfg(we_cfg),
        .sel_cfg(sel_cfg), .ptr(ptr)
    );

    busif_regfile #(.DEPTH(MEM_WORDS), .LANES(4)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(we_mem), .idx(ptr),
        .lane_en(~cbe_n), .wdata(ad_in), .rdata(mem_rd)
    );

    busif_regfile #(.DEPTH(CFG_WORDS), .LANES(4)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(we_cfg), .idx(ptr[CFG_AW-1:0]),
        .lane_en(~cbe_n), .wdata(ad_in), .rdata(cfg_rd)
    );

    assign ad_out = ad_oe ? (sel_cfg ? cfg_rd : mem_rd) : 32'h0;

    busif_parity #(.W(36)) u_rxpar (.bits({ad_in, cbe_n}),  .odd(rx_par));
    busif_parity #(.W(36)) u_txpar (.bits({ad_out, cbe_n}), .odd(tx_par));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_pend  <= 1'b0;
            chk_exp   <= 1'b0;
            perr_flag <= 1'b0;
            par_out   <= 1'b0;
            par_oe    <= 1'b0;
        end else begin
            chk_pend <= addr_ph || we_mem || we_cfg;
            chk_exp  <= rx_par;
            if (chk_pend && (par_in != chk_exp)) perr_flag <= 1'b1;
            par_oe  <= ad_oe;
            par_out <= ad_oe ? tx_par : 1'b0;
        end
    end

    assert_perr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        perr_flag |=> perr_flag);
    assert_par_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !irdy_n) |=> par_oe);
endmodule

// File: tb/sim_busif_target.sv
`timescale 1ns/100ps
module sim_busif_target;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic        par_in;
    logic [31:0] ad_out;
    logic        ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, perr_flag;

    int checks = 0, failures = 0, cyc = 0;
    logic        corrupt = 1'b0, par_drv = 1'b0;
    logic [31:0] mem_m [16];
    logic [31:0] cfg_m [4];
    logic [31:0] exp_q [$];

    always #2.5 clk = ~clk;

    busif_target u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .cbe_n(cbe_n), .ad_in(ad_in), .par_in(par_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .perr_flag(perr_flag)
    );

    always @(posedge clk) par_drv <= (^{ad_in, cbe_n}) ^ corrupt;
    assign par_in = par_drv;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: read data and its parity
    initial begin
        logic pend = 1'b0;
        logic pexp = 1'b0;
        forever begin
            @(negedge clk); #1;
            if (pend) begin
                chk("R10 par_oe", {31'b0, par_oe}, 32'd1);
                chk("R10 par_out", {31'b0, par_out}, {31'b0, pexp});
            end
            pend = 1'b0;
            if (!irdy_n && !trdy_n && ad_oe) begin
                if (exp_q.size() == 0) chk("R5 unexpected read word", ad_out, 32'hx);
                else chk("R5 read data", ad_out, exp_q.pop_front());
                pend = 1'b1;
                pexp = ^{ad_out, cbe_n};
            end
        end
    end

    task automatic run_cycle(input logic [3:0] cmd, input logic [31:0] addr, input int nwords,
                             input logic sel, input logic [3:0] be, input bit wait1,
                             input bit bad_par, input bit claim, input logic [31:0] seed,
                             output int done);
        bit cfg = cmd[3];
        bit wr  = cmd[0];
        int base = cfg ? int'(addr[3:2]) : int'(addr[5:2]);
        bit waited = 0;
        bit stopped = 0;
        int i = 0;
        int clk_n = 0;
        @(posedge clk); #1;
        frame_n = 0; irdy_n = 1; ad_in = addr; cbe_n = cmd; idsel = sel;
        forever begin
            logic [31:0] wd = seed + 32'h0101_0101 * i;
            @(posedge clk); #1;
            idsel = 0; cbe_n = be; corrupt = 0;
            if (wait1 && i == 1 && !waited) begin
                waited = 1; irdy_n = 1; ad_in = 32'hDEAD_BEEF; frame_n = 0;
            end else begin
                irdy_n = 0; ad_in = wr ? wd : 32'h0;
                frame_n = (i == nwords - 1);
                corrupt = bad_par && (i == 0);
            end
            @(negedge clk);
            if (clk_n == 0) chk(claim ? "R2 claim" : "R3 no claim", {31'b0, devsel_n}, {31'b0, !claim});
            clk_n++;
            if (!claim) begin
                chk("R3 devsel high", {31'b0, devsel_n}, 32'd1);
                i++;
                if (i == nwords) break;
            end else if (!irdy_n && !trdy_n) begin
                if (wr) begin
                    for (int b = 0; b < 4; b++) if (!be[b]) begin
                        if (cfg) cfg_m[base + i][8*b +: 8] = wd[8*b +: 8];
                        else     mem_m[base + i][8*b +: 8] = wd[8*b +: 8];
                    end
                end else begin
                    exp_q.push_back(cfg ? cfg_m[base + i] : mem_m[base + i]);
                end
                i++;
                if (!stop_n) begin stopped = !frame_n; break; end
                if (frame_n) break;
            end
        end
        @(posedge clk); #1;
        frame_n = 1; irdy_n = 1; ad_in = '0; cbe_n = 4'hF; corrupt = 0;
        if (stopped) begin
            @(negedge clk);
            chk("R7 disc trdy_n", {31'b0, trdy_n}, 32'd1);
            chk("R7 disc stop_n", {31'b0, stop_n}, 32'd0);
            chk("R7 disc devsel_n", {31'b0, devsel_n}, 32'd0);
        end
        @(negedge clk);
        chk("R8 release", {29'b0, devsel_n, trdy_n, stop_n}, 32'd7);
        done = i;
    endtask

    initial begin
        int n;
        for (int k = 0; k < 16; k++) mem_m[k] = '0;
        for (int k = 0; k < 4; k++)  cfg_m[k] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 reset strobes", {26'b0, devsel_n, trdy_n, stop_n, ad_oe, par_oe, perr_flag}, 32'h38);
        // R1: stored words read as zero
        run_cycle(4'b0110, BASE + 32'h8, 1, 0, 4'h0, 0, 0, 1, 0, n);
        // R4 R6: full-lane write burst, then read with a wait clock
        run_cycle(4'b0111, BASE, 4, 0, 4'h0, 0, 0, 1, 32'h1122_3344, n);
        chk("R6 write count", n, 4);
        run_cycle(4'b0110, BASE, 4, 0, 4'h0, 1, 0, 1, 0, n);
        chk("R6 read count", n, 4);
        // R4: partial byte enables on word 2
        run_cycle(4'b0111, BASE + 32'h8, 1, 0, 4'b1010, 0, 0, 1, 32'hAABB_CCDD, n);
        run_cycle(4'b0110, BASE + 32'h8, 1, 0, 4'h0, 0, 0, 1, 0, n);
        // R3: ignored cycles
        run_cycle(4'b0111, BASE + 32'h40, 2, 0, 4'h0, 0, 0, 0, 32'h5555_5555, n);
        run_cycle(4'b0011, BASE, 2, 0, 4'h0, 0, 0, 0, 32'h6666_6666, n);
        run_cycle(4'b1011, 32'h0, 2, 0, 4'h0, 0, 0, 0, 32'h7777_7777, n);
        run_cycle(4'b0110, BASE, 4, 0, 4'h0, 0, 0, 1, 0, n);
        // R7: burst running into window end
        run_cycle(4'b0111, BASE + 32'h38, 4, 0, 4'h0, 0, 0, 1, 32'h0A0B_0C0D, n);
        chk("R7 write stop count", n, 2);
        run_cycle(4'b0110, BASE + 32'h38, 4, 0, 4'h0, 0, 0, 1, 0, n);
        chk("R7 read stop count", n, 2);
        // R9: config space, separate from memory
        run_cycle(4'b1011, 32'h4, 5, 1, 4'h0, 0, 0, 1, 32'hC0FF_EE00, n);
        chk("R9 cfg stop count", n, 3);
        run_cycle(4'b1010, 32'h0, 4, 1, 4'h0, 0, 0, 1, 0, n);
        run_cycle(4'b0110, BASE + 32'h4, 1, 0, 4'h0, 0, 0, 1, 0, n);
        // R11: parity checking
        chk("R11 no error yet", {31'b0, perr_flag}, 32'd0);
        run_cycle(4'b0111, BASE + 32'h10, 1, 0, 4'h0, 0, 1, 1, 32'h1357_9BDF, n);
        @(negedge clk);
        chk("R11 error set", {31'b0, perr_flag}, 32'd1);
        run_cycle(4'b0110, BASE + 32'h10, 1, 0, 4'h0, 0, 0, 1, 0, n);
        chk("R11 error sticky", {31'b0, perr_flag}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule